// File: doc/BRIEF.md
# Segmented Data-Array Slot Allocator

This block finds room for one compressed line in a data array. Each slot holds eight segments, and a line of one to eight segments must fill a contiguous run inside a single slot. The search has three levels, tried in order. First, a map of fully empty slots is scanned, and the lowest empty slot is returned. If no slot is empty, four distinct sets are drawn at random and their slots are examined in turn, and the first slot with a free run that is long enough is returned. If none of those slots fits, a window is chosen inside one of the examined slots. The window is the one that costs the fewest tag invalidations to clear, and the block reports which blocks must be removed to free it. Recency and use frequency play no part in the choice.

The block keeps no copy of the array metadata. In each scan cycle it drives a slot index and reads that slot's occupancy, head flags, block sizes and reference counts back combinationally in the same cycle. A controller pulses `req` with a length. While `busy` is high, further requests are ignored. The result is valid in the single cycle in which `done` is high.

The controller has four states. `IDLE` waits for a request. It moves to `RESP` when an empty slot exists ("empty hit") and to `DRAW` otherwise ("no empty"). `DRAW` steps the random source and moves to `SCAN` once the fourth distinct set is accepted ("sets ready"). `SCAN` reads one slot per cycle. It moves to `RESP` either on a fitting run ("fit found") or after the last slot of the fourth set ("scan exhausted"). `RESP` shows the result for one cycle and returns to `IDLE` ("respond").

Top module: `seg_slot_alloc`

## Requirements
- R1: While reset is held and after its release, `done` and `busy` are 0, `res_level` is 0 and `res_evict` is 0.
- R2: If any bit of `empty_map` is set when a request is taken, the result has level 1, the lowest set index as slot, start 0, the requested length, and an evict mask of 0.
- R3: Set sampling uses a 16-bit shift register seeded with 0xACE1 at reset. Its next value is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. It steps once per `DRAW` cycle and at no other time, and it keeps its value across requests. The candidate set is the low log2(NSETS) bits of the new value.
- R4: A candidate that equals a set already drawn for the current request is discarded. Drawing stops when four distinct sets are held.
- R5: Slots are scanned one per cycle, in the order the sets were drawn and ascending way within a set, with `md_slot = set*WAYS + way`. For segment i, the bus fields are: bit i of `md_occ` (occupied), bit i of `md_head` (block head), bits [3i+2:3i] of `md_size_m1` (block size minus one), and bits [4i+3:4i] of `md_refs` (reference count).
- R6: Level 2 returns the first scanned slot that contains `len` consecutive free segments, at the lowest such start, with an evict mask of 0. The scan stops at that slot.
- R7: If no scanned slot fits, level 3 returns the window of `len` segments, among all windows of all scanned slots, with the smallest sum of reference counts over the blocks that overlap it. A tie goes to the earlier slot, then to the lower start.
- R8: On level 3, `res_evict` has bit h set exactly when the block whose head is at segment h overlaps the chosen window. On levels 1 and 2 it is 0.
- R9: `done` is a one-cycle pulse. It rises D+S cycles after the clock edge that takes the request, where D is the number of draws and S the number of slots scanned (both 0 for level 1). `busy` is high from that edge until `done`.
- R10: A request raised while `busy` is high has no effect on the result in flight and starts no later response.
- R11: Every result satisfies start + length ≤ 8, and `res_len_m1` echoes the requested length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Allocation request, taken in `IDLE` |
| req_len_m1 | input | 3 | Requested segments minus one |
| empty_map | input | NSETS*WAYS | One bit per slot, set when the slot is fully empty |
| md_slot | output | log2(NSETS*WAYS) | Slot whose metadata is read this cycle |
| md_occ | input | 8 | Occupancy bits of the read slot |
| md_head | input | 8 | Block-head bits of the read slot |
| md_size_m1 | input | 24 | Per-segment size-minus-one fields (valid at heads) |
| md_refs | input | 32 | Per-segment reference counts (valid at heads) |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Result valid this cycle |
| res_level | output | 2 | 1 empty slot, 2 free run, 3 eviction |
| res_slot | output | log2(NSETS*WAYS) | Chosen slot |
| res_start | output | 3 | First segment of the placement |
| res_len_m1 | output | 3 | Placement length minus one |
| res_evict | output | 8 | Head segments of the blocks to remove |

## Verification
A level-1 result appears in the cycle after the edge that takes the request. A level-2 or level-3 result appears D+S edges after that edge. The bench works out D and S from its own model of the shift register and the scan order. It drops `req` after the request edge, counts edges while sampling on falling edges, and checks both that `done` is first seen at the predicted count and that the fields are correct in that same cycle. For the ignored-request case, a second request is injected during the busy phase. The bench then confirms that the original result, the echoed length and the predicted latency are unchanged, and that no further `done` follows.

// File: rtl/segalloc_pkg.sv
package segalloc_pkg;
    localparam int SEGS  = 8;   // segments per slot
    localparam int SEGW  = 3;   // segment index / size-minus-one width
    localparam int REFW  = 4;   // reference count width
    localparam int COSTW = 7;   // sum of up to SEGS reference counts

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAW,
        ST_SCAN,
        ST_RESP
    } alloc_state_t;

    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_EMPTY = 2'd1,
        LVL_FIT   = 2'd2,
        LVL_EVICT = 2'd3
    } alloc_level_t;

    // mask with the low (m1 + 1) bits set
    function automatic logic [SEGS-1:0] run_mask(input logic [SEGW-1:0] m1);
        logic [SEGS-1:0] r;
        for (int i = 0; i < SEGS; i++) r[i] = (SEGW'(i) <= m1);
        return r;
    endfunction
endpackage

// File: rtl/segalloc_first_empty.sv
module segalloc_first_empty #(
    parameter int N = 64
) (
    input  logic [N-1:0]         map,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        found = |map;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (map[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/segalloc_set_picker.sv
module segalloc_set_picker #(
    parameter int          NSETS = 16,
    parameter int          NPICK = 4,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic                                draw,
    output logic [NPICK-1:0][$clog2(NSETS)-1:0] picks,
    output logic                                last_accept
);
    localparam int SETW = $clog2(NSETS);
    localparam int CNTW = $clog2(NPICK + 1);
    localparam int IDXW = $clog2(NPICK);

    logic [15:0]     lfsr_q, lfsr_nx;
    logic [SETW-1:0] cand;
    logic [CNTW-1:0] count;
    logic [IDXW-1:0] wr_idx;
    logic            accept;

    assign lfsr_nx = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    assign cand    = lfsr_nx[SETW-1:0];
    assign wr_idx  = count[IDXW-1:0];

    always_comb begin
        accept = draw && (count < CNTW'(NPICK));
        for (int i = 0; i < NPICK; i++) begin
            if (CNTW'(i) < count && picks[i] == cand) accept = 1'b0;
        end
        last_accept = accept && (count == CNTW'(NPICK - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            count  <= '0;
            picks  <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (draw) begin
            lfsr_q <= lfsr_nx;
            if (accept) begin
                picks[wr_idx] <= cand;
                count         <= count + 1'b1;
            end
        end
    end

    // R3: the random source never locks up in the all-zero state
    a_r3_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 16'h0);
    // R3: the source holds its value outside draw cycles
    a_r3_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !draw |=> lfsr_q == $past(lfsr_q));

    generate
        for (genvar i = 0; i < NPICK; i++) begin : g_pi
            for (genvar j = i + 1; j < NPICK; j++) begin : g_pj
                // R4: a complete draw never holds the same set twice
                a_r4_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                    (count == CNTW'(NPICK)) |-> picks[i] != picks[j]);
            end
        end
    endgenerate
endmodule

// File: rtl/segalloc_slot_eval.sv
module segalloc_slot_eval
    import segalloc_pkg::*;
(
    input  logic [SEGS-1:0]      occ,
    input  logic [SEGS-1:0]      head,
    input  logic [SEGS*SEGW-1:0] size_m1,
    input  logic [SEGS*REFW-1:0] refs,
    input  logic [SEGW-1:0]      len_m1,
    output logic                 fit,
    output logic [SEGW-1:0]      fit_start,
    output logic [COSTW-1:0]     vic_cost,
    output logic [SEGW-1:0]      vic_start,
    output logic [SEGS-1:0]      vic_mask
);
    logic [SEGS-1:0]  ext    [SEGS];
    logic             w_ok   [SEGS];
    logic             w_free [SEGS];
    logic [COSTW-1:0] w_cost [SEGS];
    logic [SEGS-1:0]  w_hit  [SEGS];

    generate
        for (genvar h = 0; h < SEGS; h++) begin : g_ext
            logic [2*SEGS-1:0] span;
            assign span   = {{SEGS{1'b0}}, run_mask(size_m1[h*SEGW +: SEGW])} << h;
            assign ext[h] = head[h] ? span[SEGS-1:0] : '0;
        end

        for (genvar s = 0; s < SEGS; s++) begin : g_win
            logic [2*SEGS-1:0] wm;
            logic [COSTW-1:0]  cost;
            logic [SEGS-1:0]   hit;
            assign wm        = {{SEGS{1'b0}}, run_mask(len_m1)} << s;
            assign w_ok[s]   = (wm[2*SEGS-1:SEGS] == '0);
            assign w_free[s] = w_ok[s] && ((occ & wm[SEGS-1:0]) == '0);
            always_comb begin
                cost = '0;
                hit  = '0;
                for (int b = 0; b < SEGS; b++) begin
                    if (|(ext[b] & wm[SEGS-1:0])) begin
                        hit[b] = 1'b1;
                        cost   = cost + COSTW'(refs[b*REFW +: REFW]);
                    end
                end
            end
            assign w_cost[s] = cost;
            assign w_hit[s]  = hit;
        end
    endgenerate

    always_comb begin
        fit       = 1'b0;
        fit_start = '0;
        vic_cost  = '1;
        vic_start = '0;
        vic_mask  = '0;
        for (int s = SEGS - 1; s >= 0; s--) begin
            if (w_free[s]) begin
                fit       = 1'b1;
                fit_start = SEGW'(s);
            end
            if (w_ok[s] && w_cost[s] <= vic_cost) begin
                vic_cost  = w_cost[s];
                vic_start = SEGW'(s);
                vic_mask  = w_hit[s];
            end
        end
    end
endmodule

// File: rtl/seg_slot_alloc.sv
module seg_slot_alloc
    import segalloc_pkg::*;
#(
    parameter int          NSETS = 16,
    parameter int          WAYS  = 4,
    parameter int          NPICK = 4,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req,
    input  logic [2:0]                            req_len_m1,
    input  logic [NSETS*WAYS-1:0]                 empty_map,
    output logic [$clog2(NSETS*WAYS)-1:0]         md_slot,
    input  logic [7:0]                            md_occ,
    input  logic [7:0]                            md_head,
    input  logic [23:0]                           md_size_m1,
    input  logic [31:0]                           md_refs,
    output logic                                  busy,
    output logic                                  done,
    output logic [1:0]                            res_level,
    output logic [$clog2(NSETS*WAYS)-1:0]         res_slot,
    output logic [2:0]                            res_start,
    output logic [2:0]                            res_len_m1,
    output logic [7:0]                            res_evict
);
    localparam int NSLOT = NSETS * WAYS;
    localparam int SLOTW = $clog2(NSLOT);
    localparam int SETW  = $clog2(NSETS);
    localparam int WAYW  = $clog2(WAYS);
    localparam int IDXW  = $clog2(NPICK);

    alloc_state_t state_q, state_d;

    logic [SEGW-1:0]            len_q;
    logic [IDXW-1:0]            scan_p;
    logic [WAYW-1:0]            scan_w;
    logic                       last_slot;
    logic [NPICK-1:0][SETW-1:0] picks;
    logic                       last_accept;
    logic                       empty_found;
    logic [SLOTW-1:0]           empty_idx;
    logic                       fit;
    logic [SEGW-1:0]            fit_start, vic_start, best_start;
    logic [COSTW-1:0]           vic_cost, best_cost;
    logic [SEGS-1:0]            vic_mask, best_mask;
    logic [SLOTW-1:0]           best_slot;
    logic                       cur_better;

    segalloc_first_empty #(.N(NSLOT)) u_empty (
        .map   (empty_map),
        .found (empty_found),
        .idx   (empty_idx)
    );

    segalloc_set_picker #(.NSETS(NSETS), .NPICK(NPICK), .SEED(SEED)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (state_q == ST_IDLE && req),
        .draw        (state_q == ST_DRAW),
        .picks       (picks),
        .last_accept (last_accept)
    );

    assign md_slot = {picks[scan_p], scan_w};

    segalloc_slot_eval u_eval (
        .occ       (md_occ),
        .head      (md_head),
        .size_m1   (md_size_m1),
        .refs      (md_refs),
        .len_m1    (len_q),
        .fit       (fit),
        .fit_start (fit_start),
        .vic_cost  (vic_cost),
        .vic_start (vic_start),
        .vic_mask  (vic_mask)
    );

    assign last_slot  = (scan_p == IDXW'(NPICK - 1)) && (scan_w == WAYW'(WAYS - 1));
    assign cur_better = vic_cost < best_cost;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = empty_found ? ST_RESP : ST_DRAW;
            ST_DRAW: if (last_accept) state_d = ST_SCAN;
            ST_SCAN: if (fit || last_slot) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q      <= '0;
            scan_p     <= '0;
            scan_w     <= '0;
            best_cost  <= '1;
            best_slot  <= '0;
            best_start <= '0;
            best_mask  <= '0;
            res_level  <= LVL_NONE;
            res_slot   <= '0;
            res_start  <= '0;
            res_evict  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req) begin
                    len_q     <= req_len_m1;
                    scan_p    <= '0;
                    scan_w    <= '0;
                    best_cost <= '1;
                    if (empty_found) begin
                        res_level <= LVL_EMPTY;
                        res_slot  <= empty_idx;
                        res_start <= '0;
                        res_evict <= '0;
                    end
                end
                ST_SCAN: begin
                    if (fit) begin
                        res_level <= LVL_FIT;
                        res_slot  <= md_slot;
                        res_start <= fit_start;
                        res_evict <= '0;
                    end else begin
                        if (cur_better) begin
                            best_cost  <= vic_cost;
                            best_slot  <= md_slot;
                            best_start <= vic_start;
                            best_mask  <= vic_mask;
                        end
                        if (last_slot) begin
                            res_level <= LVL_EVICT;
                            res_slot  <= cur_better ? md_slot : best_slot;
                            res_start <= cur_better ? vic_start : best_start;
                            res_evict <= cur_better ? vic_mask : best_mask;
                        end
                    end
                    if (scan_w == WAYW'(WAYS - 1)) begin
                        scan_w <= '0;
                        scan_p <= scan_p + 1'b1;
                    end else begin
                        scan_w <= scan_w + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done       = (state_q == ST_RESP);
    assign busy       = (state_q != ST_IDLE);
    assign res_len_m1 = len_q;

    // R9: the response lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R10: the captured length cannot change while a request is in progress
    a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(len_q));
    // R9: without a request the controller stays idle
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req) |=> state_q == ST_IDLE);
    // R11: a placement never runs past the end of its slot
    a_r11_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, res_start} + {1'b0, res_len_m1}) <= 4'd7);
    // R8: only an eviction result names blocks to remove
    a_r8_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_level != LVL_EVICT) |-> res_evict == '0);
    // R2: a response always carries a level
    a_r2_level_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_level != LVL_NONE);
endmodule

// File: tb/seg_slot_alloc_tb.sv
`timescale 1ns/1ps
module seg_slot_alloc_tb;
    localparam int NSETS = 16;
    localparam int WAYS  = 4;
    localparam int NSLOT = NSETS * WAYS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  req_len_m1 = '0;
    logic [NSLOT-1:0] empty_map;
    logic [5:0]  md_slot;
    logic [7:0]  md_occ, md_head;
    logic [23:0] md_size_m1;
    logic [31:0] md_refs;
    logic        busy, done;
    logic [1:0]  res_level;
    logic [5:0]  res_slot;
    logic [2:0]  res_start, res_len_m1;
    logic [7:0]  res_evict;

    logic [7:0]  m_occ  [NSLOT];
    logic [7:0]  m_head [NSLOT];
    logic [23:0] m_size [NSLOT];
    logic [31:0] m_refs [NSLOT];

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] ml = 16'hACE1;

    always #10 clk = ~clk;

    seg_slot_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_len_m1(req_len_m1),
        .empty_map(empty_map), .md_slot(md_slot), .md_occ(md_occ),
        .md_head(md_head), .md_size_m1(md_size_m1), .md_refs(md_refs),
        .busy(busy), .done(done), .res_level(res_level), .res_slot(res_slot),
        .res_start(res_start), .res_len_m1(res_len_m1), .res_evict(res_evict)
    );

    assign md_occ     = m_occ[md_slot];
    assign md_head    = m_head[md_slot];
    assign md_size_m1 = m_size[md_slot];
    assign md_refs    = m_refs[md_slot];
    always_comb for (int s = 0; s < NSLOT; s++) empty_map[s] = (m_occ[s] == 8'h00);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int s = 0; s < NSLOT; s++) begin
            m_occ[s] = '0; m_head[s] = '0; m_size[s] = '0; m_refs[s] = '0;
        end
    endtask

    task automatic put_blk(input int s, input int h, input int sz, input int r);
        m_head[s][h] = 1'b1;
        m_size[s][h*3 +: 3] = 3'(sz - 1);
        m_refs[s][h*4 +: 4] = 4'(r);
        for (int k = 0; k < sz; k++) if (h + k < 8) m_occ[s][h + k] = 1'b1;
    endtask

    task automatic load(input int pat);
        clear_all();
        for (int s = 0; s < NSLOT; s++) begin
            case (pat)
                0: if (s < 10) put_blk(s, 0, 8, 1);
                1: begin put_blk(s, 0, 4, (s % 5) + 1); put_blk(s, 4, 4, (s % 3) + 1); end
                2: put_blk(s, 0, 4, 1);
                3: begin
                    put_blk(s, 0, 2, (s % 4) + 1);       put_blk(s, 2, 1, ((s + 1) % 4) + 1);
                    put_blk(s, 3, 3, ((s + 2) % 4) + 1); put_blk(s, 6, 2, ((s + 3) % 4) + 1);
                end
                4: if (s % 4 == 3) put_blk(s, 0, 4, 1);
                   else for (int h = 0; h < 8; h += 2) put_blk(s, h, 1, 2);
                default: if (s != NSLOT - 1) put_blk(s, 0, 8, 3);
            endcase
        end
    endtask

    // reference model built from the requirements
    task automatic predict(input int lm1, output int lvl, output int slot,
                           output int st, output int msk, output int lat);
        int n, np, d, sc, best;
        int pk [4];
        n = lm1 + 1;
        for (int s = 0; s < NSLOT; s++) if (m_occ[s] == 0) begin
            lvl = 1; slot = s; st = 0; msk = 0; lat = 0; return;
        end
        np = 0; d = 0;
        while (np < 4) begin
            bit dup;
            ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
            d++;
            dup = 0;
            for (int k = 0; k < np; k++) if (pk[k] == int'(ml[3:0])) dup = 1;
            if (!dup) begin pk[np] = int'(ml[3:0]); np++; end
        end
        sc = 0; best = 1000; lvl = 3; slot = 0; st = 0; msk = 0;
        for (int p = 0; p < 4; p++) for (int w = 0; w < WAYS; w++) begin
            int s;
            s = pk[p] * WAYS + w;
            sc++;
            for (int a = 0; a + n <= 8; a++) begin
                bit ok;
                ok = 1;
                for (int k = a; k < a + n; k++) if (m_occ[s][k]) ok = 0;
                if (ok) begin lvl = 2; slot = s; st = a; msk = 0; lat = d + sc; return; end
            end
            for (int a = 0; a + n <= 8; a++) begin
                int c, m;
                c = 0; m = 0;
                for (int h = 0; h < 8; h++) if (m_head[s][h]) begin
                    int sz;
                    sz = int'(m_size[s][h*3 +: 3]) + 1;
                    if (h < a + n && h + sz > a) begin
                        c += int'(m_refs[s][h*4 +: 4]); m |= (1 << h);
                    end
                end
                if (c < best) begin best = c; slot = s; st = a; msk = m; end
            end
        end
        lat = d + sc;
    endtask

    task automatic run_req(input int lm1, input bit inject, output int lat);
        @(negedge clk); req = 1'b1; req_len_m1 = 3'(lm1);
        @(posedge clk);
        @(negedge clk); req = 1'b0;
        if (inject && !done) begin req = 1'b1; req_len_m1 = 3'd7; end
        lat = 0;
        while (!done && lat < 400) begin
            @(posedge clk); @(negedge clk); req = 1'b0; lat++;
        end
    endtask

    task automatic check_case(input int lm1, input int xl, input bit inject, input string nm);
        int lvl, slot, st, msk, lat, got;
        predict(lm1, lvl, slot, st, msk, lat);
        if (xl != 0) chk({nm, " R2/R6/R7 table level"}, lvl, xl);
        run_req(lm1, inject, got);
        chk({nm, " R9/R3/R4 latency"}, got, lat);
        chk({nm, " R9 done"}, int'(done), 1);
        chk({nm, " R2/R6/R7 level"}, int'(res_level), lvl);
        chk({nm, " R5/R6/R7 slot"}, int'(res_slot), slot);
        chk({nm, " R6/R7 start"}, int'(res_start), st);
        chk({nm, " R11 length"}, int'(res_len_m1), lm1);
        chk({nm, " R8 evict"}, int'(res_evict), msk);
    endtask

    // stimulus table: pattern, length-1, expected level
    localparam int NROW = 11;
    localparam int TBL [NROW][3] = '{
        '{0, 7, 1}, '{0, 0, 1}, '{5, 2, 1}, '{2, 3, 2}, '{2, 3, 2},
        '{4, 1, 2}, '{2, 4, 3}, '{1, 2, 3}, '{1, 5, 3}, '{3, 1, 3}, '{3, 0, 3}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 level after reset", int'(res_level), 0);
        chk("R1 evict after reset", int'(res_evict), 0);
        chk("R1 busy after reset", int'(busy), 0);

        for (int r = 0; r < NROW; r++) begin
            load(TBL[r][0]);
            check_case(TBL[r][1], TBL[r][2], 1'b0, $sformatf("row%0d", r));
        end

        // R10: a second request during the busy phase is ignored
        load(1);
        check_case(2, 3, 1'b1, "R10 inject");
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R10 no extra done", int'(done), 0);
        end
        chk("R10 idle after", int'(busy), 0);

        // R3: source state carries over; a later request still matches the model
        load(2);
        check_case(3, 2, 1'b0, "R3 carry");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule